// File: doc/BRIEF.md
# CAS-before-RAS Refresh Scheduler

This block keeps a fast-page-mode DRAM module refreshed. A free-running interval timer marks each refresh slot. Each slot adds one entry to a small backlog counter. While entries are waiting and the block is idle, it raises a refresh request toward the access arbiter.

When the arbiter grants the request, the block runs one CAS-before-RAS cycle. First it drives every byte-lane column strobe low. After a setup delay it pulls all row strobes of both module sides low together. It keeps the column strobes low for a hold time, then releases them. The row strobes stay low for the full row-active time and are then released. The block stays busy through the row precharge time so that no access starts early, and it signals completion with a one-cycle pulse.

No address is driven: the DRAM's internal row counter picks the row. All timing is given as whole clock cycles through parameters. The defaults assume a 100 MHz clock and a 15.6 µs refresh slot, which gives 1024 refreshes in 16 ms.

The request/grant pair behaves like a valid/ready handshake. `rf_want` is the valid signal and `rf_take` is the ready signal. A refresh is accepted on a rising edge where both are high. Once raised, `rf_want` stays high until it is accepted. Holding `rf_take` low is the back-pressure: slots that arrive meanwhile pile up in the backlog and are not dropped, up to its depth.

Top module: `cbr_refresh_ctrl`

## Requirements
- R1: Reset state. While reset is held and right after it is released, these outputs hold the values shown:
  - `col_stb_n` is all ones.
  - `row_stb_n` is all ones.
  - `rf_want` is 0.
  - `rf_busy` is 0.
  - `rf_done` is 0.
- R2: Refresh slots.
  - The first refresh slot falls on the SLOT_CYC-th rising edge after reset is released, so `rf_want` is first high right after that edge.
  - A new slot follows every SLOT_CYC cycles, whether or not the previous one has been served.
- R3: Handshake.
  - A refresh starts only on an edge where `rf_want` and `rf_take` are both high.
  - `rf_take` has no effect while `rf_want` is low.
  - `rf_want` is low whenever `rf_busy` is high.
- R4: CAS lead. All bits of `col_stb_n` go low in the first cycle after acceptance, CAS_LEAD_CYC cycles before `row_stb_n` falls.
- R5: CAS hold.
  - `col_stb_n` stays low for CAS_HOLD_CYC cycles after `row_stb_n` falls.
  - It then returns to all ones, while `row_stb_n` is still low.
- R6: RAS pulse. All bits of `row_stb_n` fall together, stay low together for exactly RAS_LOW_CYC cycles, and rise together.
- R7: Busy window.
  - `rf_busy` is high from the first cycle after acceptance until RAS_PRE_CYC cycles after `row_stb_n` rises.
  - Its total length is CAS_LEAD_CYC + RAS_LOW_CYC + RAS_PRE_CYC cycles.
- R8: Done pulse. `rf_done` is high for exactly one cycle: the cycle right after `rf_busy` falls.
- R9: Backlog.
  - Slots that arrive while no refresh is accepted are queued, up to MAX_OWED.
  - Each queued slot is served by its own refresh.
  - With `rf_take` held high, the queued refreshes run back to back.
  - Slots that arrive beyond MAX_OWED are discarded.
- R10: No abort. Once a refresh has started, the value of `rf_take` has no effect until `rf_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rf_take | input | 1 | Grant from the access arbiter (ready) |
| rf_want | output | 1 | Refresh request (valid) |
| rf_busy | output | 1 | Refresh cycle or its precharge in progress |
| rf_done | output | 1 | One-cycle pulse when a refresh has fully completed |
| col_stb_n | output | N_CAS | Active-low column strobes, one per byte lane |
| row_stb_n | output | N_RAS | Active-low row strobes, both module sides |

## Verification
A wrong sequencer state shows up within one cycle at the strobe pins, in one of two ways:
- the relative order of the CAS and RAS edges changes;
- the length of a low phase changes.

These errors are caught by comparing the pins cycle by cycle against the parameter-derived pattern. A wrong backlog or interval count does not show up at once. It appears only over the following slots, as a request that comes early or late, or as the wrong number of completion pulses in a back-to-back burst. The tests therefore restart from reset to fix the slot phase and count completions in windows shorter than one slot.

// File: rtl/cbr_refresh_pkg.sv
package cbr_refresh_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_LEAD,
    SQ_BOTH,
    SQ_ROW,
    SQ_PRE
  } sq_state_t;
endpackage

// File: rtl/refresh_slot_timer.sv
module refresh_slot_timer #(
  parameter int SLOT_CYC = 1560
) (
  input  logic clk,
  input  logic rst_n,
  output logic slot_tick
);
  localparam int TW = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
  localparam logic [TW-1:0] LAST = TW'(SLOT_CYC - 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign slot_tick = rst_n && (cnt_q == LAST);
endmodule

// File: rtl/refresh_backlog.sv
module refresh_backlog #(
  parameter int MAX_OWED = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic add,
  input  logic take,
  output logic owed,
  output logic [$clog2(MAX_OWED+1)-1:0] owed_cnt
);
  localparam int OW = $clog2(MAX_OWED + 1);
  localparam logic [OW-1:0] FULL = OW'(MAX_OWED);

  logic [OW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      case ({add, take})
        2'b10:   if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign owed     = (cnt_q != '0);
  assign owed_cnt = cnt_q;
endmodule

// File: rtl/cbr_sequencer.sv
module cbr_sequencer
  import cbr_refresh_pkg::*;
#(
  parameter int N_CAS        = 4,
  parameter int N_RAS        = 4,
  parameter int CAS_LEAD_CYC = 1,
  parameter int CAS_HOLD_CYC = 1,
  parameter int RAS_LOW_CYC  = 6,
  parameter int RAS_PRE_CYC  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             idle,
  output logic             done,
  output logic [N_CAS-1:0] cas_n,
  output logic [N_RAS-1:0] ras_n
);
  localparam int MAXC = (CAS_LEAD_CYC > RAS_LOW_CYC) ?
                        ((CAS_LEAD_CYC > RAS_PRE_CYC) ? CAS_LEAD_CYC : RAS_PRE_CYC) :
                        ((RAS_LOW_CYC > RAS_PRE_CYC) ? RAS_LOW_CYC : RAS_PRE_CYC);
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] L_LEAD = CW'(CAS_LEAD_CYC - 1);
  localparam logic [CW-1:0] L_BOTH = CW'(CAS_HOLD_CYC - 1);
  localparam logic [CW-1:0] L_ROW  = CW'(RAS_LOW_CYC - CAS_HOLD_CYC - 1);
  localparam logic [CW-1:0] L_PRE  = CW'(RAS_PRE_CYC - 1);

  sq_state_t st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic done_d, done_q;

  always_comb begin
    st_d   = st_q;
    cnt_d  = (cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
    done_d = 1'b0;
    case (st_q)
      SQ_IDLE: if (start) begin
        st_d  = SQ_LEAD;
        cnt_d = L_LEAD;
      end
      SQ_LEAD: if (cnt_q == '0) begin
        st_d  = SQ_BOTH;
        cnt_d = L_BOTH;
      end
      SQ_BOTH: if (cnt_q == '0) begin
        st_d  = SQ_ROW;
        cnt_d = L_ROW;
      end
      SQ_ROW: if (cnt_q == '0) begin
        st_d  = SQ_PRE;
        cnt_d = L_PRE;
      end
      SQ_PRE: if (cnt_q == '0) begin
        st_d   = SQ_IDLE;
        done_d = 1'b1;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  logic cas_on, ras_on;
  assign cas_on = (st_q == SQ_LEAD) || (st_q == SQ_BOTH);
  assign ras_on = (st_q == SQ_BOTH) || (st_q == SQ_ROW);

  for (genvar c = 0; c < N_CAS; c++) begin : g_cas
    assign cas_n[c] = ~cas_on;
  end
  for (genvar r = 0; r < N_RAS; r++) begin : g_ras
    assign ras_n[r] = ~ras_on;
  end

  assign idle = (st_q == SQ_IDLE);
  assign done = done_q;
endmodule

// File: rtl/cbr_refresh_ctrl.sv
module cbr_refresh_ctrl #(
  parameter int N_CAS        = 4,
  parameter int N_RAS        = 4,
  parameter int SLOT_CYC     = 1560,
  parameter int MAX_OWED     = 4,
  parameter int CAS_LEAD_CYC = 1,
  parameter int CAS_HOLD_CYC = 1,
  parameter int RAS_LOW_CYC  = 6,
  parameter int RAS_PRE_CYC  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rf_take,
  output logic             rf_want,
  output logic             rf_busy,
  output logic             rf_done,
  output logic [N_CAS-1:0] col_stb_n,
  output logic [N_RAS-1:0] row_stb_n
);
  localparam int OW = $clog2(MAX_OWED + 1);

  logic slot_tick, owed, seq_idle, accept;
  logic [OW-1:0] owed_cnt;

  refresh_slot_timer #(.SLOT_CYC(SLOT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick)
  );

  refresh_backlog #(.MAX_OWED(MAX_OWED)) u_backlog (
    .clk(clk), .rst_n(rst_n), .add(slot_tick), .take(accept),
    .owed(owed), .owed_cnt(owed_cnt)
  );

  assign rf_want = owed && seq_idle;
  assign accept  = rf_want && rf_take;
  assign rf_busy = !seq_idle;

  cbr_sequencer #(
    .N_CAS(N_CAS), .N_RAS(N_RAS),
    .CAS_LEAD_CYC(CAS_LEAD_CYC), .CAS_HOLD_CYC(CAS_HOLD_CYC),
    .RAS_LOW_CYC(RAS_LOW_CYC), .RAS_PRE_CYC(RAS_PRE_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .idle(seq_idle),
    .done(rf_done), .cas_n(col_stb_n), .ras_n(row_stb_n)
  );
endmodule

// File: rtl/cbr_refresh_chk.sv
module cbr_refresh_chk #(
  parameter int N_CAS       = 4,
  parameter int N_RAS       = 4,
  parameter int MAX_OWED    = 4,
  parameter int RAS_LOW_CYC = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rf_want,
  input logic             rf_busy,
  input logic             rf_done,
  input logic [N_CAS-1:0] col_stb_n,
  input logic [N_RAS-1:0] row_stb_n,
  input logic [$clog2(MAX_OWED+1)-1:0] owed_cnt
);
  logic [15:0] low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || row_stb_n[0]) low_cnt <= '0;
    else                        low_cnt <= low_cnt + 1'b1;
  end

  // R1: the strobes stay idle while reset is held
  always_comb begin
    if (!rst_n) assert_reset_idle_R1: assert (&col_stb_n && &row_stb_n);
  end

  assert_no_want_when_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_want && rf_busy));

  assert_cas_before_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(row_stb_n[0]) |-> (col_stb_n == '0) && ($past(col_stb_n) == '0));

  assert_cas_rises_under_ras_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(col_stb_n[0]) |-> (row_stb_n == '0));

  assert_ras_lines_together_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (row_stb_n == '0) || (&row_stb_n));

  assert_ras_low_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(row_stb_n[0]) |-> (low_cnt == 16'(RAS_LOW_CYC)));

  assert_ras_implies_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (row_stb_n == '0) |-> rf_busy);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rf_done |=> !rf_done);

  assert_backlog_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    owed_cnt <= ($clog2(MAX_OWED+1))'(MAX_OWED));
endmodule

bind cbr_refresh_ctrl cbr_refresh_chk #(
  .N_CAS(N_CAS), .N_RAS(N_RAS), .MAX_OWED(MAX_OWED), .RAS_LOW_CYC(RAS_LOW_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rf_want(rf_want), .rf_busy(rf_busy),
  .rf_done(rf_done), .col_stb_n(col_stb_n), .row_stb_n(row_stb_n),
  .owed_cnt(owed_cnt)
);

// File: tb/cbr_refresh_ctrl_bench.sv
module cbr_refresh_ctrl_bench;
  localparam int NC = 4, NR = 4, SLOT = 100, MAXO = 4;
  localparam int LEAD = 2, HOLD = 2, RLOW = 6, PRE = 4;
  localparam int BUSY = LEAD + RLOW + PRE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rf_take = 1'b0;
  logic rf_want, rf_busy, rf_done;
  logic [NC-1:0] col_stb_n;
  logic [NR-1:0] row_stb_n;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  cbr_refresh_ctrl #(
    .N_CAS(NC), .N_RAS(NR), .SLOT_CYC(SLOT), .MAX_OWED(MAXO),
    .CAS_LEAD_CYC(LEAD), .CAS_HOLD_CYC(HOLD), .RAS_LOW_CYC(RLOW), .RAS_PRE_CYC(PRE)
  ) u_cbr_refresh_ctrl (
    .clk(clk), .rst_n(rst_n), .rf_take(rf_take), .rf_want(rf_want),
    .rf_busy(rf_busy), .rf_done(rf_done), .col_stb_n(col_stb_n), .row_stb_n(row_stb_n)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    rf_take = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // R1 reset values; R2 first slot timing; R3 grant without request ignored
  task automatic t_reset_and_slot();
    do_reset();
    check("R1 cas idle", col_stb_n, 4'hF);
    check("R1 ras idle", row_stb_n, 4'hF);
    check("R1 want", rf_want, 0);
    check("R1 busy", rf_busy, 0);
    check("R1 done", rf_done, 0);
    rf_take = 1'b1;
    for (int i = 1; i < SLOT; i++) begin
      @(negedge clk);
      if (rf_busy || col_stb_n != 4'hF || rf_want) begin
        check("R3 take ignored without want", {rf_busy, rf_want, col_stb_n}, 4'hF);
        break;
      end
    end
    rf_take = 1'b0;
    check("R2 want low before slot", rf_want, 0);
    @(negedge clk);
    check("R2 want after slot", rf_want, 1);
    repeat (5) @(negedge clk);
    check("R3 want held until accepted", rf_want, 1);
  endtask

  // R4 R5 R6 R7 R8 R10: cycle-by-cycle strobe pattern, single-cycle grant
  task automatic t_sequence();
    int errs;
    errs = 0;
    do_reset();
    while (!rf_want) @(negedge clk);
    rf_take = 1'b1;
    @(negedge clk);
    rf_take = 1'b0;
    for (int j = 1; j <= BUSY + 1; j++) begin
      logic ec, er, eb, ed;
      ec = !(j <= LEAD + HOLD);
      er = !(j > LEAD && j <= LEAD + RLOW);
      eb = (j <= BUSY);
      ed = (j == BUSY + 1);
      if (col_stb_n != {NC{ec}}) begin errs++; check("R4/R5 cas pattern", col_stb_n, {NC{ec}}); end
      if (row_stb_n != {NR{er}}) begin errs++; check("R6 ras pattern", row_stb_n, {NR{er}}); end
      if (rf_busy != eb) begin errs++; check("R7 busy window", rf_busy, eb); end
      if (rf_done != ed) begin errs++; check("R8 done pulse", rf_done, ed); end
      if (rf_want) begin errs++; check("R3 want while busy", rf_want, 0); end
      @(negedge clk);
    end
    check("R10 full sequence after single-cycle grant", errs, 0);
    check("R8 done falls", rf_done, 0);
    check("R3 want clear after service", rf_want, 0);
  endtask

  // R9 / R2: queued slots served back to back
  task automatic t_backlog(input int slots, input int exp_done, input string tag);
    int n;
    n = 0;
    do_reset();
    repeat (slots * SLOT + 5) @(negedge clk);
    rf_take = 1'b1;
    repeat (80) begin
      @(negedge clk);
      if (rf_done) n++;
    end
    rf_take = 1'b0;
    check(tag, n, exp_done);
    check("R9 backlog drained", rf_want, 0);
  endtask

  initial begin
    t_reset_and_slot();
    t_sequence();
    t_backlog(2, 2, "R9 two queued refreshes");
    t_backlog(3, 3, "R2 slots accumulate while waiting");
    t_backlog(6, MAXO, "R9 backlog saturates");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule